// File: doc/BRIEF.md
# Thermally Gated Performance-State Request Filter

This block sits between the software path that asks for a new operating frequency and the logic that applies it. Each request arrives as a single-cycle write strobe carrying a target frequency code. When no thermal control event is in progress, the request is applied at once. During a thermal event, the block compares the requested code with the thermal-optimized target code supplied by the thermal controller. A request at or below that target is applied immediately. A request above it is parked and applied only when the event ends.

Only one request can be parked. A later request always supersedes an earlier one, and the later request is judged on its own by the same rule. The applied code is reported together with a one-cycle commit strobe, so downstream sequencing sees exactly one event per new operating point. A pending flag reports that a deferred request is waiting.

Top module: `pstate_therm_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `commit` is 0, `pending` is 0 and `applied_code` equals `rst_code`.
- R2: A strobed request (`req_wr`=1) sampled while `therm_active`=0 gives `commit`=1 and `applied_code`=`req_code` in the following cycle.
- R3: A strobed request sampled while `therm_active`=1, with `req_code` greater than `therm_target` (unsigned compare), gives no commit, leaves `applied_code` unchanged, and sets `pending` to 1 in the following cycle.
- R4: A strobed request sampled while `therm_active`=1, with `req_code` less than `therm_target`, is applied in the following cycle with `commit`=1, and `pending` is 0 in that cycle.
- R5: A request whose code equals `therm_target` during a thermal event counts as not higher and is applied exactly as in R4.
- R6: When `pending` is 1, `therm_active` is 0 and `req_wr` is 0 at a clock edge, the parked code becomes `applied_code` after that edge, with `commit`=1 and `pending`=0 in the same cycle.
- R7: A new request arriving while one is parked replaces it. If the new request is deferred, the later code is the one replayed. If it is applied, the parked request is discarded and `pending` clears.
- R8: `commit` is 1 only in the cycle after an apply from R2, R4, R5, R6 or R9. In every other cycle `commit` is 0 and `applied_code` holds its value.
- R9: If a request is strobed in the cycle where a parked request would be released, only the new request is applied. The parked code is never committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_code | input | W | Operating-point code loaded at reset |
| req_wr | input | 1 | Single-cycle request write strobe |
| req_code | input | W | Requested frequency code |
| therm_active | input | 1 | Thermal control event in progress |
| therm_target | input | W | Thermal-optimized target frequency code |
| applied_code | output | W | Currently applied operating-point code |
| commit | output | 1 | One-cycle pulse when a new operating point is applied |
| pending | output | 1 | A deferred request is waiting |

## Verification
The hardest case to reach is a release that coincides with a fresh request, because it needs a request already parked, the thermal flag falling, and a strobe in that same cycle. The bench first parks a high code during an event, then drops the event and strobes a new code in one step. It does the same with a below-target request that should discard the parked one. An exhaustive sweep over every request and target code with the event both on and off covers the boundary where the two codes are equal. Each deferral is followed by an explicit release step.

// File: rtl/pstate_filt_pkg.sv
// Package: shared decision encoding for the thermally gated request filter.
// Assumes nothing beyond being compiled before the modules that import it.
package pstate_filt_pkg;

    // Outcome of one cycle's evaluation
    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,  // nothing changes
        DEC_APPLY  = 2'd1,  // incoming request is applied now
        DEC_DEFER  = 2'd2,  // incoming request is parked
        DEC_REPLAY = 2'd3   // parked request is released
    } pf_dec_e;

endpackage

// File: rtl/pstate_req_classify.sv
// Module: pstate_req_classify
// Decides, combinationally, what happens to the operating point this cycle.
// A strobed request always takes priority over releasing a parked one, so
// the latest request wins. Assumes codes are unsigned frequency ratios in
// which a larger code means a higher frequency.
module pstate_req_classify
    import pstate_filt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         req_wr,
    input  logic [W-1:0] req_code,
    input  logic         therm_active,
    input  logic [W-1:0] therm_target,
    input  logic         pend_valid,
    output pf_dec_e      decision
);

    logic above_target;

    // Purpose: flag a request that would run faster than the thermal target
    always_comb begin
        above_target = (req_code > therm_target);
    end

    // Purpose: pick the decision for this cycle
    always_comb begin
        decision = DEC_NONE;
        if (req_wr) begin
            if (therm_active && above_target) begin
                decision = DEC_DEFER;
            end else begin
                decision = DEC_APPLY;
            end
        end else if (pend_valid && !therm_active) begin
            decision = DEC_REPLAY;
        end
    end

endmodule

// File: rtl/pstate_pend_slot.sv
// Module: pstate_pend_slot
// Single-entry holding slot for a deferred request. A deferral overwrites
// the slot. An apply or a replay empties it. Assumes the decision input comes
// from pstate_req_classify.
module pstate_pend_slot
    import pstate_filt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pf_dec_e      decision,
    input  logic [W-1:0] req_code,
    output logic         pend_valid,
    output logic [W-1:0] pend_code
);

    // Purpose: track whether a deferred request is waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
        end else begin
            unique case (decision)
                DEC_DEFER:             pend_valid <= 1'b1;
                DEC_APPLY, DEC_REPLAY: pend_valid <= 1'b0;
                default:               pend_valid <= pend_valid;
            endcase
        end
    end

    // Purpose: capture the code of the latest deferred request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code <= '0;
        end else if (decision == DEC_DEFER) begin
            pend_code <= req_code;
        end
    end

endmodule

// File: rtl/pstate_commit_stage.sv
// Module: pstate_commit_stage
// Holds the applied operating-point code and generates the one-cycle commit
// pulse. Assumes rst_code is stable while rst_n is low.
module pstate_commit_stage
    import pstate_filt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_code,
    input  pf_dec_e      decision,
    input  logic [W-1:0] req_code,
    input  logic [W-1:0] pend_code,
    output logic [W-1:0] applied_code,
    output logic         commit
);

    logic [W-1:0] next_code;
    logic         do_apply;

    // Purpose: choose the source of a new operating point
    always_comb begin
        do_apply  = (decision == DEC_APPLY) || (decision == DEC_REPLAY);
        next_code = (decision == DEC_REPLAY) ? pend_code : req_code;
    end

    // Purpose: register the applied code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied_code <= rst_code;
        end else if (do_apply) begin
            applied_code <= next_code;
        end
    end

    // Purpose: pulse commit once for each applied operating point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= 1'b0;
        end else begin
            commit <= do_apply;
        end
    end

endmodule

// File: rtl/pstate_therm_gate.sv
// Module: pstate_therm_gate (top)
// Filters software performance-state requests against a thermal event. It
// applies, defers or replays each one, and reports the applied code with a
// commit pulse and a pending flag. Assumes req_wr is a single-cycle strobe
// and that therm_target is valid whenever therm_active is high.
module pstate_therm_gate
    import pstate_filt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_code,
    input  logic         req_wr,
    input  logic [W-1:0] req_code,
    input  logic         therm_active,
    input  logic [W-1:0] therm_target,
    output logic [W-1:0] applied_code,
    output logic         commit,
    output logic         pending
);

    pf_dec_e      decision;
    logic         pend_valid;
    logic [W-1:0] pend_code;

    pstate_req_classify #(.W(W)) i_classify (
        .req_wr       (req_wr),
        .req_code     (req_code),
        .therm_active (therm_active),
        .therm_target (therm_target),
        .pend_valid   (pend_valid),
        .decision     (decision)
    );

    pstate_pend_slot #(.W(W)) i_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .decision   (decision),
        .req_code   (req_code),
        .pend_valid (pend_valid),
        .pend_code  (pend_code)
    );

    pstate_commit_stage #(.W(W)) i_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_code     (rst_code),
        .decision     (decision),
        .req_code     (req_code),
        .pend_code    (pend_code),
        .applied_code (applied_code),
        .commit       (commit)
    );

    // Purpose: expose the holding-slot state
    always_comb begin
        pending = pend_valid;
    end

endmodule

// File: rtl/pstate_therm_gate_chk.sv
// Module: pstate_therm_gate_chk
// Port-level properties of pstate_therm_gate. Bound to every instance.
module pstate_therm_gate_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] rst_code,
    input logic         req_wr,
    input logic [W-1:0] req_code,
    input logic         therm_active,
    input logic [W-1:0] therm_target,
    input logic [W-1:0] applied_code,
    input logic         commit,
    input logic         pending
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!commit && !pending && applied_code == $past(rst_code))); // R1

    AST_IDLE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !therm_active) |=> (commit && applied_code == $past(req_code))); // R2

    AST_DEFER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && therm_active && req_code > therm_target) |=> (!commit && pending)); // R3

    AST_PASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && therm_active && req_code <= therm_target)
        |=> (commit && !pending && applied_code == $past(req_code))); // R4

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !therm_active && !req_wr) |=> (commit && !pending)); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_wr && !(pending && !therm_active)) |=> !commit); // R8

    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_wr && !(pending && !therm_active)) |=> $stable(applied_code)); // R8

endmodule

bind pstate_therm_gate pstate_therm_gate_chk #(.W(W)) i_chk (.*);

// File: tb/test_pstate_therm_gate.sv
module test_pstate_therm_gate;

    localparam int W = 4;
    localparam int NCODE = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] rst_code = 4'd5;
    logic         req_wr = 1'b0;
    logic [W-1:0] req_code = '0;
    logic         therm_active = 1'b0;
    logic [W-1:0] therm_target = '0;
    logic [W-1:0] applied_code;
    logic         commit;
    logic         pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [W-1:0] m_applied;
    logic         m_pend = 1'b0;
    logic [W-1:0] m_held;

    always #4 clk = ~clk;

    pstate_therm_gate #(.W(W)) i_pstate_therm_gate (
        .clk(clk), .rst_n(rst_n), .rst_code(rst_code),
        .req_wr(req_wr), .req_code(req_code),
        .therm_active(therm_active), .therm_target(therm_target),
        .applied_code(applied_code), .commit(commit), .pending(pending)
    );

    task automatic check(string tag, logic [W-1:0] exp_code, logic exp_c, logic exp_p);
        checks++;
        if (applied_code !== exp_code || commit !== exp_c || pending !== exp_p) begin
            errors++;
            $display("FAIL %s: code=%0d commit=%0b pending=%0b expected code=%0d commit=%0b pending=%0b",
                     tag, applied_code, commit, pending, exp_code, exp_c, exp_p);
        end
    endtask

    // drive one cycle at the falling edge, check outputs at the next falling edge
    task automatic step(logic wr, logic [W-1:0] code, logic act, logic [W-1:0] tgt);
        string tag;
        logic  exp_c;
        req_wr = wr; req_code = code; therm_active = act; therm_target = tgt;
        exp_c = 1'b0;
        tag = "R8";
        if (wr) begin
            if (act && code > tgt) begin
                tag = m_pend ? "R7" : "R3";
                m_pend = 1'b1; m_held = code;
            end else begin
                if (!act) tag = (m_pend) ? "R9" : "R2";
                else if (code == tgt) tag = "R5";
                else tag = m_pend ? "R7" : "R4";
                m_applied = code; exp_c = 1'b1; m_pend = 1'b0;
            end
        end else if (m_pend && !act) begin
            tag = "R6";
            m_applied = m_held; exp_c = 1'b1; m_pend = 1'b0;
        end
        @(negedge clk);
        check(tag, m_applied, exp_c, m_pend);
        req_wr = 1'b0;
    endtask

    task automatic do_reset(logic [W-1:0] code);
        rst_code = code; rst_n = 1'b0; req_wr = 1'b0;
        @(negedge clk); @(negedge clk);
        m_applied = code; m_pend = 1'b0;
        check("R1", code, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset(4'd5);
        step(1'b0, 4'd0, 1'b0, 4'd0);                    // R8 idle
        // exhaustive sweep: R2, R3, R4, R5 and R6
        for (int a = 0; a < 2; a++) begin
            for (int t = 0; t < NCODE; t++) begin
                for (int c = 0; c < NCODE; c++) begin
                    step(1'b1, W'(c), a[0], W'(t));
                    if (m_pend) begin
                        step(1'b0, 4'd0, 1'b1, W'(t));   // R8 still held
                        step(1'b0, 4'd0, 1'b0, W'(t));   // R6 release
                    end
                    step(1'b0, 4'd0, 1'b0, W'(t));       // R8 quiet
                end
            end
        end
        // R7: a later deferred request replaces the parked one
        step(1'b1, 4'd12, 1'b1, 4'd6);
        step(1'b1, 4'd9, 1'b1, 4'd6);
        step(1'b0, 4'd0, 1'b0, 4'd6);
        // R7: a below-target request discards the parked one
        step(1'b1, 4'd14, 1'b1, 4'd6);
        step(1'b1, 4'd3, 1'b1, 4'd6);
        step(1'b0, 4'd0, 1'b0, 4'd6);
        // R9: request strobed in the release cycle wins
        step(1'b1, 4'd15, 1'b1, 4'd2);
        step(1'b1, 4'd7, 1'b0, 4'd2);
        step(1'b0, 4'd0, 1'b0, 4'd2);
        // R1: reset drops a parked request
        step(1'b1, 4'd13, 1'b1, 4'd1);
        do_reset(4'd10);
        step(1'b0, 4'd0, 1'b0, 4'd1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule